// File: doc/BRIEF.md
# Nested-Loop Affine Stream Sequencer

This block drives a streaming memory port with addresses and access strobes that follow nested counted loops. Up to six loop levels are configured, each with an extent (trip count), an address stride and a schedule stride. For every point of the loop nest the block forms an address equal to a base address plus the sum over levels of stride times loop index. It also forms a schedule time in the same affine way from a base time and per-level time strides. When a free-running cycle counter reaches that schedule time, the block raises its enable for one cycle and presents the address.

Neither value uses a multiplier. Each generator keeps one running value per loop level. A step adds the stride of the level that advances. Every inner level that wraps is reloaded with that same new value. One loop-index counter bank decides, for both generators, which level advances and which levels wrap.

A start pulse captures the configuration and begins a run. After the final point of the nest is issued, the block raises done and freezes until the next start.

Top module: `affine_stream_ctrl`

## Requirements
- R1: While reset is high, and after it, with no start seen, `en_o`, `done_o` and `addr_o` are all zero.
- R2: A start pulse captures the configuration and begins a run. Points are visited with level 0 (bits [15:0] of each per-level vector) varying fastest. Level i occupies bits [16i+15:16i]. The number of points is the product of the effective extents of the active levels.
- R3: The address issued for loop indices (i0..i5) is `cfg_addr_base` plus the sum of address stride times index over all levels, modulo 2^16.
- R4: The schedule value of a point is `cfg_sched_base` plus the sum of schedule stride times index, modulo 2^16. Counting the clock edge that samples start as edge 0, the point with schedule value S raises `en_o` for the single cycle that follows edge S+1. `en_o` is low in every cycle that holds no scheduled point. Schedule values must rise strictly from point to point.
- R5: `cfg_levels` sets the number of active levels. A value of 0 acts as 1, and a value above 6 acts as 6. Levels at or above the active count behave as extent 1, so their extents and strides have no effect.
- R6: An extent of 0 on an active level behaves as an extent of 1.
- R7: `done_o` rises in the same cycle as the enable of the final point. It then stays high, with `en_o` low and `addr_o` unchanged, until the next start.
- R8: A start pulse during a run abandons that run at once. No enable of the abandoned run appears afterwards, and the new run follows R2 to R4 from that start.
- R9: Strides are added in two's complement modulo 2^16, so values at or above 0x8000 act as negative steps and the address wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse: capture configuration and begin a run |
| cfg_levels | input | 3 | Number of active loop levels (clamped to 1..6) |
| cfg_extent | input | 96 | Per-level trip counts, level i at bits [16i+15:16i] |
| cfg_addr_stride | input | 96 | Per-level address strides |
| cfg_sched_stride | input | 96 | Per-level schedule (cycle) strides |
| cfg_addr_base | input | 16 | Address of the first point |
| cfg_sched_base | input | 16 | Schedule time of the first point, in cycles after start |
| addr_o | output | 16 | Address of the point being issued |
| en_o | output | 1 | Access enable, high for one cycle per point |
| done_o | output | 1 | High from the final point's enable until the next start |

## Verification
The final point's enable and the done flag are raised in the same cycle by one registered decision. A fault that shifts done by a cycle, or that drops the last enable, therefore shows up at the edge of every run. The bench compares `en_o`, `addr_o` and `done_o` in each cycle against a reference nest computed from the same configuration. The six-level case uses consecutive schedule values, so enables come back-to-back and every level wraps on a step issued in the cycle that follows an enable. A further case issues start while a run is in flight, which makes a restart coincide with pending schedule matches. It then checks that none of the old run's enables survive.

// File: rtl/affine_pkg.sv
package affine_pkg;

  parameter int unsigned LEVELS = 6;
  parameter int unsigned DW     = 16;

  // map a requested level count onto the supported range 1..nl
  function automatic int clamp_levels(input int req, input int nl);
    if (req < 1)       return 1;
    else if (req > nl) return nl;
    else               return req;
  endfunction

endpackage

// File: rtl/aff_iter_domain.sv
module aff_iter_domain #(
  parameter int unsigned NL = 6,
  parameter int unsigned W  = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          step,
  input  logic [W-1:0]  emax [NL],
  output logic [NL-1:0] inc_sel,
  output logic [NL-1:0] wrap,
  output logic          last
);

  logic [W-1:0]  idx [NL];
  logic [NL-1:0] at_max;

  for (genvar i = 0; i < NL; i++) begin : g_cmp
    assign at_max[i] = (idx[i] == emax[i]);
  end

  assign last = &at_max;

  // lowest level not at its limit advances; everything below it wraps
  always_comb begin
    logic seen;
    inc_sel = '0;
    seen    = 1'b0;
    for (int i = 0; i < NL; i++) begin
      if (!seen && !at_max[i]) begin
        inc_sel[i] = 1'b1;
        seen       = 1'b1;
      end
    end
    seen = 1'b0;
    for (int i = NL - 1; i >= 0; i--) begin
      wrap[i] = seen;
      seen    = seen | inc_sel[i];
    end
  end

  for (genvar i = 0; i < NL; i++) begin : g_idx
    always_ff @(posedge clk) begin
      if (rst || clear)
        idx[i] <= '0;
      else if (step) begin
        if (inc_sel[i])   idx[i] <= idx[i] + W'(1);
        else if (wrap[i]) idx[i] <= '0;
      end
    end

    // R2
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
      idx[i] <= emax[i]);
  end

endmodule

// File: rtl/aff_recur.sv
module aff_recur #(
  parameter int unsigned NL = 6,
  parameter int unsigned W  = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic [W-1:0]  init,
  input  logic [W-1:0]  stride [NL],
  input  logic          step,
  input  logic [NL-1:0] inc_sel,
  input  logic [NL-1:0] wrap,
  output logic [W-1:0]  cur
);

  // val[i]: value of the current point with all levels below i at index 0
  logic [W-1:0] val [NL];
  logic [W-1:0] nv;

  always_comb begin
    nv = '0;
    for (int i = 0; i < NL; i++) begin
      if (inc_sel[i]) nv = val[i] + stride[i];
    end
  end

  for (genvar i = 0; i < NL; i++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (rst)
        val[i] <= '0;
      else if (clear)
        val[i] <= init;
      else if (step && (inc_sel[i] || wrap[i]))
        val[i] <= nv;
    end
  end

  assign cur = val[0];

  // R3
  inner_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !clear && inc_sel[0]) |=> (val[0] == $past(val[0]) + $past(stride[0])));

endmodule

// File: rtl/affine_stream_ctrl.sv
module affine_stream_ctrl #(
  parameter int unsigned NLVL = affine_pkg::LEVELS,
  parameter int unsigned W    = affine_pkg::DW,
  parameter int unsigned LW   = $clog2(NLVL + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [LW-1:0]   cfg_levels,
  input  logic [NLVL*W-1:0] cfg_extent,
  input  logic [NLVL*W-1:0] cfg_addr_stride,
  input  logic [NLVL*W-1:0] cfg_sched_stride,
  input  logic [W-1:0]    cfg_addr_base,
  input  logic [W-1:0]    cfg_sched_base,
  output logic [W-1:0]    addr_o,
  output logic            en_o,
  output logic            done_o
);

  logic [W-1:0] emax_d [NLVL];
  logic [W-1:0] emax_q [NLVL];
  logic [W-1:0] astr_q [NLVL];
  logic [W-1:0] sstr_q [NLVL];

  logic            running;
  logic [W-1:0]    cyc;
  logic [NLVL-1:0] inc_sel;
  logic [NLVL-1:0] wrap;
  logic            last_it;
  logic [W-1:0]    addr_cur;
  logic [W-1:0]    sched_cur;
  logic            match;
  logic            step;
  int              lv_eff;

  // effective loop limits; inactive or zero-extent levels collapse to one point
  always_comb begin
    lv_eff = affine_pkg::clamp_levels(int'(cfg_levels), NLVL);
    for (int i = 0; i < NLVL; i++) begin
      if (i < lv_eff && cfg_extent[i*W +: W] != '0)
        emax_d[i] = cfg_extent[i*W +: W] - W'(1);
      else
        emax_d[i] = '0;
    end
  end

  for (genvar i = 0; i < NLVL; i++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (rst) begin
        emax_q[i] <= '0;
        astr_q[i] <= '0;
        sstr_q[i] <= '0;
      end else if (start) begin
        emax_q[i] <= emax_d[i];
        astr_q[i] <= cfg_addr_stride[i*W +: W];
        sstr_q[i] <= cfg_sched_stride[i*W +: W];
      end
    end
  end

  aff_iter_domain #(.NL(NLVL), .W(W)) u_dom (
    .clk     (clk),
    .rst     (rst),
    .clear   (start),
    .step    (step),
    .emax    (emax_q),
    .inc_sel (inc_sel),
    .wrap    (wrap),
    .last    (last_it)
  );

  aff_recur #(.NL(NLVL), .W(W)) u_addr (
    .clk     (clk),
    .rst     (rst),
    .clear   (start),
    .init    (cfg_addr_base),
    .stride  (astr_q),
    .step    (step),
    .inc_sel (inc_sel),
    .wrap    (wrap),
    .cur     (addr_cur)
  );

  aff_recur #(.NL(NLVL), .W(W)) u_sched (
    .clk     (clk),
    .rst     (rst),
    .clear   (start),
    .init    (cfg_sched_base),
    .stride  (sstr_q),
    .step    (step),
    .inc_sel (inc_sel),
    .wrap    (wrap),
    .cur     (sched_cur)
  );

  assign match = running && (cyc == sched_cur);
  assign step  = match && !last_it;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cyc     <= '0;
      en_o    <= 1'b0;
      done_o  <= 1'b0;
      addr_o  <= '0;
    end else if (start) begin
      running <= 1'b1;
      cyc     <= '0;
      en_o    <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      en_o <= match;
      if (match) addr_o <= addr_cur;
      if (running) cyc <= cyc + W'(1);
      if (match && last_it) begin
        running <= 1'b0;
        done_o  <= 1'b1;
      end
    end
  end

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start) |=> (done_o && !en_o));

  // R7
  done_with_en_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> en_o);

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start) |=> $stable(addr_o));

  // R4
  no_en_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    en_o |-> !$past(done_o));

endmodule

// File: tb/tb_affine_stream_ctrl.sv
module tb_affine_stream_ctrl;

  localparam int NL   = 6;
  localparam int W    = 16;
  localparam int MAXC = 512;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [2:0]    cfg_levels = 3'd1;
  logic [W-1:0]  ext [NL];
  logic [W-1:0]  ast [NL];
  logic [W-1:0]  sst [NL];
  logic [NL*W-1:0] cfg_extent, cfg_addr_stride, cfg_sched_stride;
  logic [W-1:0]  cfg_addr_base = '0;
  logic [W-1:0]  cfg_sched_base = '0;
  logic [W-1:0]  addr_o;
  logic          en_o, done_o;

  int checks = 0;
  int errors = 0;

  bit           exp_en   [MAXC];
  logic [W-1:0] exp_addr [MAXC];
  int           last_s;

  always #4 clk = ~clk;

  for (genvar i = 0; i < NL; i++) begin : g_pack
    assign cfg_extent[i*W +: W]       = ext[i];
    assign cfg_addr_stride[i*W +: W]  = ast[i];
    assign cfg_sched_stride[i*W +: W] = sst[i];
  end

  affine_stream_ctrl dut (
    .clk              (clk),
    .rst              (rst),
    .start            (start),
    .cfg_levels       (cfg_levels),
    .cfg_extent       (cfg_extent),
    .cfg_addr_stride  (cfg_addr_stride),
    .cfg_sched_stride (cfg_sched_stride),
    .cfg_addr_base    (cfg_addr_base),
    .cfg_sched_base   (cfg_sched_base),
    .addr_o           (addr_o),
    .en_o             (en_o),
    .done_o           (done_o)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // reference nest built straight from the requirements
  task automatic build_ref();
    int lv, n;
    int e [NL];
    lv = (cfg_levels == 0) ? 1 : ((cfg_levels > 6) ? 6 : int'(cfg_levels));
    n = 1;
    for (int i = 0; i < NL; i++) begin
      e[i] = (i < lv && ext[i] != 0) ? int'(ext[i]) : 1;
      n = n * e[i];
    end
    for (int k = 0; k < MAXC; k++) begin
      exp_en[k] = 1'b0;
      exp_addr[k] = '0;
    end
    for (int j = 0; j < n; j++) begin
      int rem, d;
      logic [W-1:0] a, s;
      rem = j;
      a = cfg_addr_base;
      s = cfg_sched_base;
      for (int i = 0; i < NL; i++) begin
        d = rem % e[i];
        rem = rem / e[i];
        a = a + W'(int'(ast[i]) * d);
        s = s + W'(int'(sst[i]) * d);
      end
      exp_en[int'(s)] = 1'b1;
      exp_addr[int'(s)] = a;
      if (j == n - 1) last_s = int'(s);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic run_case(input string req);
    logic [W-1:0] held;
    build_ref();
    pulse_start();
    for (int k = 0; k <= last_s; k++) begin
      @(negedge clk);
      check({req, " enable"}, W'(en_o), W'(exp_en[k]));
      if (exp_en[k]) check({req, " address"}, addr_o, exp_addr[k]);
      check({req, " R7 done timing"}, W'(done_o), W'(k == last_s));
    end
    held = addr_o;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R7 done held", W'(done_o), W'(1));
      check("R7 enable low after done", W'(en_o), W'(0));
      check("R7 address frozen", addr_o, held);
    end
  endtask

  task automatic clear_cfg();
    for (int i = 0; i < NL; i++) begin
      ext[i] = 16'd1; ast[i] = '0; sst[i] = '0;
    end
    cfg_addr_base = '0;
    cfg_sched_base = '0;
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    check("R1 enable in reset", W'(en_o), W'(0));
    check("R1 done in reset", W'(done_o), W'(0));
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 enable idle", W'(en_o), W'(0));
    check("R1 done idle", W'(done_o), W'(0));
    check("R1 address idle", addr_o, W'(0));
  endtask

  task automatic test_two_level();
    clear_cfg();
    cfg_levels = 3'd2;
    ext[0] = 16'd4; ext[1] = 16'd3;
    ast[0] = 16'd1; ast[1] = 16'd16;
    sst[0] = 16'd1; sst[1] = 16'd5;
    cfg_addr_base = 16'h0100; cfg_sched_base = 16'd2;
    run_case("R2 R3 R4 two-level");
  endtask

  task automatic test_six_level();
    clear_cfg();
    cfg_levels = 3'd6;
    for (int i = 0; i < NL; i++) begin
      ext[i] = 16'd2;
      ast[i] = W'(3 + 7 * i * i);
      sst[i] = W'(1 << i);
    end
    cfg_addr_base = 16'h0400;
    run_case("R2 R3 R4 six-level back-to-back");
  endtask

  task automatic test_clamp();
    clear_cfg();
    cfg_levels = 3'd0;
    ext[0] = 16'd3; ext[1] = 16'd9; ext[2] = 16'd5;
    ast[0] = 16'd2; ast[1] = 16'h0777;
    sst[0] = 16'd3; sst[1] = 16'd1;
    cfg_addr_base = 16'h0020; cfg_sched_base = 16'd1;
    run_case("R5 levels zero");
    cfg_levels = 3'd2;
    ext[0] = 16'd2; ext[1] = 16'd3; ext[2] = 16'd7; ext[3] = 16'd4;
    ast[1] = 16'd10; ast[2] = 16'h1234;
    sst[1] = 16'd6; sst[2] = 16'd1;
    run_case("R5 upper levels ignored");
    cfg_levels = 3'd7;
    for (int i = 0; i < NL; i++) begin
      ext[i] = 16'd2; ast[i] = W'(1 << i); sst[i] = W'(2 << i);
    end
    run_case("R5 levels seven");
  endtask

  task automatic test_zero_extent();
    clear_cfg();
    cfg_levels = 3'd2;
    ext[0] = 16'd0; ext[1] = 16'd3;
    ast[0] = 16'd5; ast[1] = 16'd8;
    sst[0] = 16'd1; sst[1] = 16'd4;
    cfg_addr_base = 16'h0050;
    run_case("R6 zero extent");
  endtask

  task automatic test_negative();
    clear_cfg();
    cfg_levels = 3'd3;
    ext[0] = 16'd3; ext[1] = 16'd2; ext[2] = 16'd2;
    ast[0] = 16'hFFFE; ast[1] = 16'h8000; ast[2] = 16'h0003;
    sst[0] = 16'd2; sst[1] = 16'd7; sst[2] = 16'd15;
    cfg_addr_base = 16'h0003; cfg_sched_base = 16'd0;
    run_case("R9 negative stride");
  endtask

  task automatic test_restart();
    clear_cfg();
    cfg_levels = 3'd1;
    ext[0] = 16'd4; ast[0] = 16'd1; sst[0] = 16'd3;
    cfg_addr_base = 16'h0BAD; cfg_sched_base = 16'd6;
    pulse_start();
    repeat (7) @(negedge clk);
    check("R8 first run issued", W'(en_o || (addr_o == 16'h0BAD)), W'(1));
    cfg_levels = 3'd2;
    ext[0] = 16'd2; ext[1] = 16'd4;
    ast[0] = 16'd4; ast[1] = 16'd64;
    sst[0] = 16'd5; sst[1] = 16'd11;
    cfg_addr_base = 16'h0200; cfg_sched_base = 16'd0;
    run_case("R8 restart mid-run");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_cfg();
    test_reset();
    test_two_level();
    test_six_level();
    test_clamp();
    test_zero_extent();
    test_negative();
    test_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule